// File: doc/BRIEF.md
# Systolic Array Schedule Controller

This block produces every per-cycle enable needed to drive an output-stationary matrix-multiply grid of `ROWS x COLS` processing elements. A one-cycle start pulse clears an internal cycle index to zero. The index then advances by one per clock. Shared comparators on that index generate four enables for each element: operand feed, element invoke, accumulate permission and a single-cycle result write. Each element's schedule is delayed by its anti-diagonal offset `pos = r + c`. Each element's schedule also assumes a fixed four-cycle multiplier latency.

The contraction depth arrives as a runtime input and is captured at start. Thresholds of the form depth-plus-constant are therefore formed by adders in hardware. One adder and one comparator exist per distinct threshold value, and every element that uses that threshold shares them. A done pulse marks the end of the run, after which the block returns to idle.

The processing elements, operand shift registers and memories sit outside this block. They consume the flat enable vectors directly. In those vectors, bit `r*COLS + c` belongs to the element at row `r` and column `c`.

Top module: `sysched_ctrl`

## Requirements
- R1: After reset, and before any start pulse, every enable bit and `done_o` are low.
- R2: A start pulse seen at a clock edge while idle makes the index 0 in the following cycle, so bit 0 of `feed_en_o` is high in that cycle whenever the captured depth is at least 1.
- R3: `feed_en_o` bit of an element in row 0 or column 0 is high exactly while `pos <= idx < depth + pos`; feed bits of every other element stay low.
- R4: `invoke_en_o` bit of an element is high exactly while `pos + 1 <= idx < depth + pos + 5`.
- R5: `accum_en_o` bit of an element is high exactly while its invoke bit is high and `idx >= pos + 5`.
- R6: `write_stb_o` bit of an element is high for exactly one cycle, when `idx == depth + pos + 5`.
- R7: `done_o` is high for exactly one cycle, when `idx == ROWS + COLS + depth + 4`; from the next cycle all enables are low until the next start.
- R8: Depth is captured at start; changes on `depth_i` and further start pulses during a run do not change that run's schedule.
- R9: Element (r, c) owns bit `r*COLS + c` of every per-element vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| depth_i | input | DEPTH_W | Contraction depth, captured at start |
| feed_en_o | output | ROWS*COLS | Operand feed enable per element (boundary elements only) |
| invoke_en_o | output | ROWS*COLS | Element invoke enable |
| accum_en_o | output | ROWS*COLS | Accumulate permission accompanying invoke |
| write_stb_o | output | ROWS*COLS | One-cycle result write strobe |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bound checker watches several relations on every cycle. Each write strobe lasts a single cycle and arrives just after that element's invoke window closes. Accumulate permission never appears outside invoke. The done pulse is one cycle wide and leaves every enable low behind it. The exact window edges depend on the captured depth, the anti-diagonal offset and the bit placement in the flat vectors, so only the bench's scenarios can show them. Those scenarios compare every vector on every cycle against a model derived from the interval rules. They run for two grid shapes, for depths including 1, and with depth and start disturbed mid-run.

// File: rtl/sysched_pkg.sv
package sysched_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // index must hold ROWS + COLS + 4 + max depth
  function automatic int calc_idx_w(int depth_w, int rows, int cols);
    return depth_w + $clog2(rows + cols + 5) + 1;
  endfunction

endpackage

// File: rtl/sysched_counter.sv
module sysched_counter
  import sysched_pkg::*;
#(
  parameter int ROWS    = 3,
  parameter int COLS    = 4,
  parameter int DEPTH_W = 8,
  parameter int IDX_W   = calc_idx_w(DEPTH_W, ROWS, COLS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               run_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               done_o
);

  localparam int LIMIT_BASE = ROWS + COLS + 4;

  run_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [IDX_W-1:0]   limit;
  logic               at_limit;

  assign limit    = IDX_W'(LIMIT_BASE) + IDX_W'(depth_q);
  assign at_limit = (idx_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      depth_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
            depth_q <= depth_i;
          end
        end
        default: begin
          if (at_limit) state_q <= ST_IDLE;
          else          idx_q   <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign run_o   = (state_q == ST_RUN);
  assign depth_o = depth_q;
  assign done_o  = (state_q == ST_RUN) && at_limit;

endmodule

// File: rtl/sysched_grid.sv
module sysched_grid #(
  parameter int ROWS    = 3,
  parameter int COLS    = 4,
  parameter int DEPTH_W = 8,
  parameter int IDX_W   = 12
) (
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 run_i,
  input  logic [DEPTH_W-1:0]   depth_i,
  output logic [ROWS*COLS-1:0] feed_o,
  output logic [ROWS*COLS-1:0] invoke_o,
  output logic [ROWS*COLS-1:0] accum_o,
  output logic [ROWS*COLS-1:0] write_o
);

  localparam int NPOS = ROWS + COLS - 1;  // distinct anti-diagonals
  localparam int NTH  = NPOS + 5;         // threshold constants 0..NPOS+4
  localparam int MUL_LAT = 4;

  // shared constant thresholds: idx >= k
  for (genvar k = 1; k < NTH; k++) begin : g_ge
    if (k <= NPOS || k > MUL_LAT) begin : g_on
      logic hit;
      assign hit = (idx_i >= IDX_W'(k));
    end
  end

  // shared depth-relative thresholds: depth + k
  for (genvar k = 0; k < NTH; k++) begin : g_dk
    if (k < NPOS || k > MUL_LAT) begin : g_on
      logic [IDX_W-1:0] sum;
      logic             lt;
      assign sum = IDX_W'(depth_i) + IDX_W'(k);
      assign lt  = (idx_i < sum);
      if (k > MUL_LAT) begin : g_eq
        logic hit;
        assign hit = (idx_i == sum);
      end
    end
  end

  logic [ROWS*COLS-1:0] feed_w, invoke_w, accum_w, write_w;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int P = r + c;
      localparam int B = r * COLS + c;

      if (r == 0 || c == 0) begin : g_feed
        if (P == 0) begin : g_lo0
          assign feed_w[B] = run_i & g_dk[0].g_on.lt;
        end else begin : g_lon
          assign feed_w[B] = run_i & g_ge[P].g_on.hit & g_dk[P].g_on.lt;
        end
      end else begin : g_nofeed
        assign feed_w[B] = 1'b0;
      end

      assign invoke_w[B] = run_i & g_ge[P+1].g_on.hit & g_dk[P+MUL_LAT+1].g_on.lt;
      assign accum_w[B]  = invoke_w[B] & g_ge[P+MUL_LAT+1].g_on.hit;
      assign write_w[B]  = run_i & g_dk[P+MUL_LAT+1].g_on.g_eq.hit;
    end
  end

  assign feed_o   = feed_w;
  assign invoke_o = invoke_w;
  assign accum_o  = accum_w;
  assign write_o  = write_w;

endmodule

// File: rtl/sysched_ctrl.sv
module sysched_ctrl
  import sysched_pkg::*;
#(
  parameter int ROWS    = 3,
  parameter int COLS    = 4,
  parameter int DEPTH_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DEPTH_W-1:0]   depth_i,
  output logic [ROWS*COLS-1:0] feed_en_o,
  output logic [ROWS*COLS-1:0] invoke_en_o,
  output logic [ROWS*COLS-1:0] accum_en_o,
  output logic [ROWS*COLS-1:0] write_stb_o,
  output logic                 done_o
);

  localparam int IDX_W = calc_idx_w(DEPTH_W, ROWS, COLS);

  logic [IDX_W-1:0]   idx;
  logic               run;
  logic [DEPTH_W-1:0] depth_q;

  sysched_counter #(
    .ROWS(ROWS), .COLS(COLS), .DEPTH_W(DEPTH_W), .IDX_W(IDX_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .depth_i (depth_i),
    .idx_o   (idx),
    .run_o   (run),
    .depth_o (depth_q),
    .done_o  (done_o)
  );

  sysched_grid #(
    .ROWS(ROWS), .COLS(COLS), .DEPTH_W(DEPTH_W), .IDX_W(IDX_W)
  ) u_grid (
    .idx_i    (idx),
    .run_i    (run),
    .depth_i  (depth_q),
    .feed_o   (feed_en_o),
    .invoke_o (invoke_en_o),
    .accum_o  (accum_en_o),
    .write_o  (write_stb_o)
  );

endmodule

// File: rtl/sysched_ctrl_chk.sv
module sysched_ctrl_chk #(
  parameter int ROWS    = 3,
  parameter int COLS    = 4,
  parameter int DEPTH_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [DEPTH_W-1:0]   depth_i,
  input logic [ROWS*COLS-1:0] feed_en_o,
  input logic [ROWS*COLS-1:0] invoke_en_o,
  input logic [ROWS*COLS-1:0] accum_en_o,
  input logic [ROWS*COLS-1:0] write_stb_o,
  input logic                 done_o
);

  logic unused_in;
  assign unused_in = start_i ^ (^depth_i);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (feed_en_o == '0 && invoke_en_o == '0 &&
                accum_en_o == '0 && write_stb_o == '0));

  a_r6_write_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_stb_o != '0) |=> ((write_stb_o & $past(write_stb_o)) == '0));

  a_r6_write_closes_invoke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_stb_o != '0) |-> ((write_stb_o & invoke_en_o) == '0 &&
                             (write_stb_o & ~$past(invoke_en_o)) == '0));

  a_r5_accum_in_invoke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accum_en_o & ~invoke_en_o) == '0);

endmodule

bind sysched_ctrl sysched_ctrl_chk #(
  .ROWS(ROWS), .COLS(COLS), .DEPTH_W(DEPTH_W)
) u_chk (.*);

// File: tb/tb_sysched_ctrl.sv
module tb_sysched_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int RA = 3, CA = 4;   // main grid
  localparam int RB = 1, CB = 2;   // small grid, gaps in threshold set
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] depth = '0;

  logic [RA*CA-1:0] feed_a, inv_a, acc_a, wr_a;
  logic [RB*CB-1:0] feed_b, inv_b, acc_b, wr_b;
  logic done_a, done_b;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysched_ctrl #(.ROWS(RA), .COLS(CA), .DEPTH_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .depth_i(depth),
    .feed_en_o(feed_a), .invoke_en_o(inv_a), .accum_en_o(acc_a),
    .write_stb_o(wr_a), .done_o(done_a));

  sysched_ctrl #(.ROWS(RB), .COLS(CB), .DEPTH_W(DW)) dut_s (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .depth_i(depth),
    .feed_en_o(feed_b), .invoke_en_o(inv_b), .accum_en_o(acc_b),
    .write_stb_o(wr_b), .done_o(done_b));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model from interval rules; sel: 0 feed, 1 invoke, 2 accum, 3 write
  function automatic logic [11:0] model(int rows, int cols, int n, int d, int sel);
    logic [11:0] v = '0;
    bit run = (n >= 0) && (n <= rows + cols + d + 4);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        int p = r + c;
        bit inv = run && n >= p + 1 && n < d + p + 5;
        bit b;
        case (sel)
          0:       b = run && (r == 0 || c == 0) && n >= p && n < d + p;
          1:       b = inv;
          2:       b = inv && n >= p + 5;
          default: b = run && n == d + p + 5;
        endcase
        v[r*cols+c] = b;
      end
    end
    return v;
  endfunction

  task automatic cycle_check(string tag, int n, int d);
    chk({tag, "/R3 feed A"},   12'(feed_a), model(RA, CA, n, d, 0));
    chk({tag, "/R4 invoke A"}, 12'(inv_a),  model(RA, CA, n, d, 1));
    chk({tag, "/R5 accum A"},  12'(acc_a),  model(RA, CA, n, d, 2));
    chk({tag, "/R6 write A"},  12'(wr_a),   model(RA, CA, n, d, 3));
    chk({tag, "/R7 done A"},   12'(done_a), 12'(n == RA + CA + d + 4));
    chk({tag, "/R3 feed B"},   12'(feed_b), model(RB, CB, n, d, 0));
    chk({tag, "/R4 invoke B"}, 12'(inv_b),  model(RB, CB, n, d, 1));
    chk({tag, "/R5 accum B"},  12'(acc_b),  model(RB, CB, n, d, 2));
    chk({tag, "/R6 write B"},  12'(wr_b),   model(RB, CB, n, d, 3));
    chk({tag, "/R7 done B"},   12'(done_b), 12'(n == RB + CB + d + 4));
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R1: idle outputs all low
    chk("R1 idle A", 12'(feed_a | inv_a | acc_a | wr_a) | 12'(done_a), '0);
    chk("R1 idle B", 12'(feed_b | inv_b | acc_b | wr_b) | 12'(done_b), '0);
  endtask

  // full run; mid != 0 disturbs depth and start at index 3 (R8)
  task automatic run_case(string tag, int d, bit mid, int nd);
    int last = RA + CA + d + 4;
    @(negedge clk);
    start = 1'b1;
    depth = DW'(d);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= last; n++) begin
      if (n == 0) chk({tag, "/R2 first feed"}, 12'(feed_a[0]), 12'(d > 0));
      if (n == 2) chk({tag, "/R9 bit r1c0 invoke"}, 12'(inv_a[CA]), 12'(d + 6 > 2));
      cycle_check(tag, n, d);
      if (mid && n == 3) begin
        start = 1'b1;
        depth = DW'(nd);
      end
      @(negedge clk);
      start = 1'b0;
    end
    cycle_check(tag, last + 1, d);  // idle after done (R7)
  endtask

  initial begin
    test_reset();
    run_case("d1",  1,  1'b0, 0);
    run_case("d4",  4,  1'b0, 0);
    run_case("d17", 17, 1'b0, 0);
    run_case("R8 mid", 6, 1'b1, 2);
    run_case("R8 mid up", 2, 1'b1, 9);
    summary();
    $finish;
  end

endmodule